// File: doc/BRIEF.md
# Expansion DRAM Column Strobe Steering

This block sits beside the host memory controller of an 8-bit machine that has a built-in 16K RAM bank and an added 16K DRAM bank. On every RAS cycle it decides which bank answers. When the upper half of the 32K window is addressed (address bit 14 high) while the host's active-low ROM select stays high, it withholds the host CAS from the built-in RAM and issues its own column strobe to the added bank instead. The I/O window at 0xFD00–0xFEFF and the register window at 0xFF00–0xFF3F never reach the added bank. The vector area 0xFFFC–0xFFFF is served by RAM whenever ROM is mapped out.

The expansion strobe is timed from the host's row/column multiplexer select, delayed by a parameterised number of fast-clock cycles after it enters the column phase. The strobe is held until RAS rises. The block also drives the added bank's multiplexed address bus. The row phase carries the low CPU byte, which also carries refresh rows. The column phase places six column bits on pins 1 to 6.

Top module: `cas_steer`

## Requirements
- R1: When the address latched at RAS fall has bit 14 high, the ROM select is high, and neither excluded window is hit, int_cas_n stays high all cycle and xcas_n goes low once the column delay has elapsed, provided the host has requested CAS.
- R2: When the latched address bit 14 is low, or the ROM select is low, int_cas_n equals the host cas_n and xcas_n stays high.
- R3: Addresses 0xFD00–0xFEFF and 0xFF00–0xFF3F never drive xcas_n low, even with the ROM select high. int_cas_n then follows the host cas_n.
- R4: Addresses 0xFFFC–0xFFFF with the ROM select high are served by the expansion bank: xcas_n goes low.
- R5: xcas_n goes low no earlier than DLY rising clk edges after mux_col is first sampled high in the cycle. It is low after exactly DLY edges.
- R6: Once low, xcas_n stays low after the host cas_n rises. It returns high in the same instant that ras_n goes high.
- R7: In a cycle where the host cas_n never goes low (RAS-only refresh), both xcas_n and int_cas_n stay high, and xma carries addr[7:0] as the row.
- R8: The bank choice is captured at the first clk edge that sees ras_n low, and is held until ras_n rises. Changes to addr or rom_cs_n later in the cycle do not alter either strobe.
- R9: With mux_col low, xma equals addr[7:0]. With mux_col high, xma[6:1] equals addr[13:8], and xma[7] and xma[0] are 0.
- R10: While rst_n is low, and right after reset with ras_n high, both xcas_n and int_cas_n are high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Active-low reset |
| ras_n | input | 1 | Host row strobe, active low |
| cas_n | input | 1 | Host column strobe, active low |
| mux_col | input | 1 | Host address multiplexer select, high in column phase |
| rom_cs_n | input | 1 | Host ROM select, active low |
| addr | input | 16 | CPU address |
| int_cas_n | output | 1 | Column strobe to the built-in RAM |
| xcas_n | output | 1 | Column strobe to the expansion bank |
| xma | output | 8 | Multiplexed address to the expansion bank |

## Verification
The assertions assume that the host strobes obey DRAM ordering. RAS falls before the multiplexer enters the column phase, the multiplexer goes high before the host CAS falls, and every strobe is synchronous to clk. The stimulus drives all inputs at falling clk edges and keeps that order in every cycle. It holds each level for at least one full clk period, so the sampled RAS fall and the delay count see clean transitions. The address and ROM select are changed mid-cycle only to exercise the hold behaviour.

// File: rtl/cas_steer.sv
module cas_steer #(
  parameter int DLY = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ras_n,
  input  logic       cas_n,
  input  logic       mux_col,
  input  logic       rom_cs_n,
  input  logic [15:0] addr,
  output logic       int_cas_n,
  output logic       xcas_n,
  output logic [7:0] xma
);
  localparam int CW = $clog2(DLY + 1);
  localparam logic [CW-1:0] CMAX = CW'(DLY);

  logic          ras_q;
  logic          ext_sel;
  logic          cas_seen;
  logic [CW-1:0] cnt;
  logic          col_ready;
  logic          in_io;
  logic          in_regs;
  logic          hit;
  logic          ras_fall;

  assign in_io    = (addr[15:8] == 8'hFD) || (addr[15:8] == 8'hFE);
  assign in_regs  = (addr[15:6] == 10'h3FC);
  assign hit      = addr[14] & rom_cs_n & ~in_io & ~in_regs;
  assign ras_fall = ras_q & ~ras_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_q    <= 1'b1;
      ext_sel  <= 1'b0;
      cas_seen <= 1'b0;
      cnt      <= '0;
    end else begin
      ras_q <= ras_n;
      if (ras_n) ext_sel <= 1'b0;
      else if (ras_fall) ext_sel <= hit;
      if (ras_n) cas_seen <= 1'b0;
      else if (!cas_n) cas_seen <= 1'b1;
      if (ras_n || !mux_col) cnt <= '0;
      else if (cnt != CMAX) cnt <= cnt + 1'b1;
    end
  end

  assign col_ready = (cnt == CMAX);
  assign int_cas_n = cas_n | ext_sel;
  assign xcas_n    = ~(ext_sel & col_ready & (cas_seen | ~cas_n) & ~ras_n);
  assign xma       = mux_col ? {1'b0, addr[13:8], 1'b0} : addr[7:0];

  a_r1_exclusive_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    !(!int_cas_n && !xcas_n));
  a_r6_release_with_ras: assert property (@(posedge clk) disable iff (!rst_n)
    ras_n |-> xcas_n);
  a_r7_no_cas_no_xcas: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_n && !cas_seen) |-> xcas_n);
  a_r8_choice_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n && !ras_q) |=> $stable(ext_sel));
  a_r5_column_phase_only: assert property (@(posedge clk) disable iff (!rst_n)
    !xcas_n |-> mux_col);
  a_r2_internal_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_sel) |-> (int_cas_n == cas_n));
endmodule

// File: tb/sim_cas_steer.sv
module sim_cas_steer;
  localparam int PERIOD = 10;
  localparam int DLY = 3;
  localparam int NV = 16;
  localparam logic [17:0] VEC [NV] = '{
    {1'b1,1'b1,16'h4000}, {1'b0,1'b0,16'h4000}, {1'b0,1'b1,16'h3FFF},
    {1'b0,1'b1,16'h8123}, {1'b1,1'b1,16'hC000}, {1'b0,1'b0,16'hC000},
    {1'b1,1'b1,16'hFCFF}, {1'b0,1'b1,16'hFD00}, {1'b0,1'b1,16'hFEFF},
    {1'b0,1'b1,16'hFF00}, {1'b0,1'b1,16'hFF3F}, {1'b1,1'b1,16'hFF40},
    {1'b1,1'b1,16'hFFFC}, {1'b1,1'b1,16'hFFFF}, {1'b1,1'b1,16'h7FFF},
    {1'b0,1'b0,16'hFFFF}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ras_n = 1'b1, cas_n = 1'b1, mux_col = 1'b0, rom_cs_n = 1'b1;
  logic [15:0] addr = 16'h0000;
  logic int_cas_n, xcas_n;
  logic [7:0] xma;
  int checks = 0;
  int errors = 0;

  always #(PERIOD/2) clk = ~clk;

  cas_steer #(.DLY(DLY)) u0 (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .mux_col(mux_col),
    .rom_cs_n(rom_cs_n), .addr(addr), .int_cas_n(int_cas_n), .xcas_n(xcas_n), .xma(xma)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic bus_cycle(input logic [15:0] a, input logic cs, input logic ext);
    logic [15:0] a2;
    logic cs2;
    @(negedge clk);
    addr = a; rom_cs_n = cs; ras_n = 1'b0;
    #1 chk("R9 row", xma, a[7:0]);
    @(negedge clk);
    mux_col = 1'b1; cas_n = 1'b0;
    #1 chk("R9 col", xma, {1'b0, a[13:8], 1'b0});
    chk(ext ? "R1 int" : "R2/R3 int", {7'd0, int_cas_n}, {7'd0, ext});
    for (int i = 1; i < DLY; i++) @(negedge clk);
    chk("R5 early", {7'd0, xcas_n}, 8'd1);
    @(negedge clk);
    chk(ext ? "R1/R4 xcas" : "R2/R3 xcas", {7'd0, xcas_n}, {7'd0, ~ext});
    a2 = ext ? 16'h0000 : 16'h4000;
    cs2 = 1'b1;
    addr = a2; rom_cs_n = cs2;
    @(negedge clk);
    chk("R8 hold xcas", {7'd0, xcas_n}, {7'd0, ~ext});
    chk("R8 hold int", {7'd0, int_cas_n}, {7'd0, ext});
    cas_n = 1'b1;
    @(negedge clk);
    chk("R6 held", {7'd0, xcas_n}, {7'd0, ~ext});
    ras_n = 1'b1;
    #1 chk("R6 release", {7'd0, xcas_n}, 8'd1);
    @(negedge clk);
    mux_col = 1'b0;
  endtask

  initial begin
    #(PERIOD * 100000);
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 in reset", {6'd0, xcas_n, int_cas_n}, 8'd3);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 after reset", {6'd0, xcas_n, int_cas_n}, 8'd3);

    for (int k = 0; k < NV; k++)
      bus_cycle(VEC[k][15:0], VEC[k][16], VEC[k][17]);

    @(negedge clk);
    addr = 16'h4055; rom_cs_n = 1'b1; ras_n = 1'b0;
    #1 chk("R7 row", xma, 8'h55);
    @(negedge clk);
    mux_col = 1'b1;
    repeat (DLY + 1) @(negedge clk);
    chk("R7 refresh", {6'd0, xcas_n, int_cas_n}, 8'd3);
    ras_n = 1'b1; mux_col = 1'b0;

    @(negedge clk);
    addr = 16'h0123; rom_cs_n = 1'b1; ras_n = 1'b0;
    @(negedge clk);
    mux_col = 1'b1;
    @(negedge clk);
    cas_n = 1'b0;
    #1 chk("R2 follow low", {7'd0, int_cas_n}, 8'd0);
    @(negedge clk);
    cas_n = 1'b1;
    #1 chk("R2 follow high", {7'd0, int_cas_n}, 8'd1);
    @(negedge clk);
    ras_n = 1'b1; mux_col = 1'b0;
    repeat (2) @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule